// File: doc/BRIEF.md
# GPIO Controller with Edge Interrupts

This block manages 28 general-purpose pins behind a small word-addressed register bus. Software picks, pin by pin, whether the pin drives or receives, and changes the output latch only through two write-one strobes: one raises bits, one lowers them. The current level of every pin can be read at any time. The block also watches each synchronized input for rising and falling transitions and records them in a sticky status word.

Each status bit stays set until software writes a one to it. The status word drives the interrupt outputs. Pins 0 to 10 each have a line of their own, and pins 11 to 27 share one merged line. A wake-enable mask selects which pending bits also raise a wake request for the power controller. The pads are modelled as three separate vectors: input level, output value and output enable.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Each pin input passes through two flip-flops before it is used. A change on `pin_in` shows in the level register after the second rising clock edge, and not after the first.
- R2: A read at offset 0x00 returns the synchronized level of all 28 pins, whatever their direction.
- R3: A write to offset 0x08 sets every output latch bit written with one. A write to offset 0x0C clears every latch bit written with one. Bits written with zero keep their value. Reads at 0x08 and 0x0C return the latch, and `pin_out` follows the latch.
- R4: Offset 0x04 holds the direction word: a one makes the pin an output. `pin_oe` equals this word and changes only when it is written.
- R5: Offset 0x10 enables rising-edge detection and offset 0x14 enables falling-edge detection, one bit per pin. With both bits set, either transition is detected. With neither set, transitions are ignored.
- R6: A detected enabled edge sets the pin's bit in the status word at offset 0x18. Writing one to a status bit clears it, and writing zero leaves it unchanged.
- R7: `irq_low[i]` is high exactly while status bit i is set, for i from 0 to 10.
- R8: `irq_high` is the OR of status bits 11 to 27.
- R9: Offset 0x1C holds the wake mask. `wake_req` is high while any status bit whose mask bit is set is pending.
- R10: After reset, all readable registers are zero and every output is low.
- R11: When a new edge and a clear write hit the same status bit in one cycle, the bit ends up set.
- R12: Read bits 31 to 28 are always zero. A misaligned access (address bits 1:0 not zero) has no effect and reads zero. Writes to the level register at 0x00 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Access strobe for the current cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; zero when no read is in progress |
| pin_in | input | 28 | Raw pin levels from the pads |
| pin_out | output | 28 | Output latch value |
| pin_oe | output | 28 | Output enable per pin (direction word) |
| irq_low | output | 11 | Dedicated interrupt lines for pins 0 to 10 |
| irq_high | output | 1 | Merged interrupt line for pins 11 to 27 |
| wake_req | output | 1 | Wake request from masked pending status |

## Verification
The bench targets the cycle on which a transition becomes visible. A design with one synchronizer stage too few or too many would show the new level, or set the status bit, one cycle early or late. It times a clear write to land in the same cycle as a fresh edge on that bit; a design that lets the clear win would drop the interrupt. It writes zero masks to the set, clear and status registers, and a design that treats those as full-word writes would disturb the latch or lose pending bits. It also checks the boundary between pin 10 and pin 11, where a mis-split would move an event between a dedicated line and the shared line. Finally it checks that both edge enables together catch both directions, where a design with the enables wrongly combined would miss one of them.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int NPINS  = 28;
    localparam int NDEDIC = 11;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;
    localparam int SYNC_STAGES = 2;

    // Register index taken from address bits [4:2]
    typedef enum logic [2:0] {
        RG_LEVEL = 3'd0,
        RG_DIR   = 3'd1,
        RG_SET   = 3'd2,
        RG_CLR   = 3'd3,
        RG_RISE  = 3'd4,
        RG_FALL  = 3'd5,
        RG_STAT  = 3'd6,
        RG_WAKE  = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 28,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.chain[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            sync_d.chain[s] = sync_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_out = sync_q.chain[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_edge_pkg::*;
#(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_stb,
    input  reg_sel_e     wr_idx,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] out_lat,
    output logic [W-1:0] dir_word,
    output logic [W-1:0] rise_en,
    output logic [W-1:0] fall_en,
    output logic [W-1:0] wake_en,
    output logic [W-1:0] clr_mask
);

    typedef struct packed {
        logic [W-1:0] lat;
        logic [W-1:0] dir;
        logic [W-1:0] rise;
        logic [W-1:0] fall;
        logic [W-1:0] wake;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d   = regs_q;
        clr_mask = '0;
        if (wr_stb) begin
            case (wr_idx)
                RG_DIR:  regs_d.dir  = wr_data;
                RG_SET:  regs_d.lat  = regs_q.lat | wr_data;
                RG_CLR:  regs_d.lat  = regs_q.lat & ~wr_data;
                RG_RISE: regs_d.rise = wr_data;
                RG_FALL: regs_d.fall = wr_data;
                RG_STAT: clr_mask    = wr_data;
                RG_WAKE: regs_d.wake = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign out_lat  = regs_q.lat;
    assign dir_word = regs_q.dir;
    assign rise_en  = regs_q.rise;
    assign fall_en  = regs_q.fall;
    assign wake_en  = regs_q.wake;

endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status
);

    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] stat;
    } det_t;

    det_t det_d, det_q;
    logic [W-1:0] rise_hit, fall_hit;

    always_comb begin
        det_d    = det_q;
        rise_hit = level & ~det_q.prev & rise_en;
        fall_hit = ~level & det_q.prev & fall_en;
        det_d.prev = level;
        // A new edge overrides a clear in the same cycle
        det_d.stat = (det_q.stat & ~clr_mask) | rise_hit | fall_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    assign status = det_q.stat;

endmodule

// File: rtl/gpio_irq_map.sv
module gpio_irq_map #(
    parameter int W      = 28,
    parameter int NDEDIC = 11
) (
    input  logic              [W-1:0] status,
    input  logic              [W-1:0] wake_en,
    output logic         [NDEDIC-1:0] irq_ded,
    output logic                      irq_shared,
    output logic                      wake_req
);

    for (genvar i = 0; i < NDEDIC; i++) begin : g_ded
        assign irq_ded[i] = status[i];
    end

    if (NDEDIC < W) begin : g_shared
        assign irq_shared = |status[W-1:NDEDIC];
    end else begin : g_no_shared
        assign irq_shared = 1'b0;
    end

    assign wake_req = |(status & wake_en);

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int NP = NPINS,
    parameter int ND = NDEDIC,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [NP-1:0] pin_in,
    output logic [NP-1:0] pin_out,
    output logic [NP-1:0] pin_oe,
    output logic [ND-1:0] irq_low,
    output logic          irq_high,
    output logic          wake_req
);

    localparam int PAD_W = DW - NP;

    logic          aligned, wr_stb, rd_stb;
    reg_sel_e      idx;
    logic [NP-1:0] lvl_sync, lat, dirw, ren, fen, wken, clr, stat;
    logic [NP-1:0] rd_word;
    logic          unused_wdata_hi;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign idx     = reg_sel_e'(bus_addr[4:2]);
    assign wr_stb  = bus_en & bus_we & aligned;
    assign rd_stb  = bus_en & ~bus_we & aligned;
    assign unused_wdata_hi = ^bus_wdata[DW-1:NP];

    gpio_sync #(.W(NP), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (lvl_sync)
    );

    gpio_regs #(.W(NP)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_idx   (idx),
        .wr_data  (bus_wdata[NP-1:0]),
        .out_lat  (lat),
        .dir_word (dirw),
        .rise_en  (ren),
        .fall_en  (fen),
        .wake_en  (wken),
        .clr_mask (clr)
    );

    gpio_edge_det #(.W(NP)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (lvl_sync),
        .rise_en  (ren),
        .fall_en  (fen),
        .clr_mask (clr),
        .status   (stat)
    );

    gpio_irq_map #(.W(NP), .NDEDIC(ND)) u_irq (
        .status     (stat),
        .wake_en    (wken),
        .irq_ded    (irq_low),
        .irq_shared (irq_high),
        .wake_req   (wake_req)
    );

    always_comb begin
        rd_word = '0;
        if (rd_stb) begin
            case (idx)
                RG_LEVEL: rd_word = lvl_sync;
                RG_DIR:   rd_word = dirw;
                RG_SET,
                RG_CLR:   rd_word = lat;
                RG_RISE:  rd_word = ren;
                RG_FALL:  rd_word = fen;
                RG_STAT:  rd_word = stat;
                RG_WAKE:  rd_word = wken;
                default:  rd_word = '0;
            endcase
        end
    end

    assign bus_rdata = {{PAD_W{1'b0}}, rd_word};
    assign pin_out   = lat;
    assign pin_oe    = dirw;

endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
    parameter int NP = 28,
    parameter int ND = 11,
    parameter int HW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_en,
    input logic          bus_we,
    input logic [4:0]    bus_addr,
    input logic [ND-1:0] wd_low,
    input logic [HW-1:0] rd_hi,
    input logic [NP-1:0] pin_out,
    input logic [NP-1:0] pin_oe,
    input logic [ND-1:0] irq_low,
    input logic          irq_high,
    input logic          wake_req
);

    logic stat_wr, dir_wr, lat_wr;
    assign stat_wr = bus_en && bus_we && (bus_addr == 5'h18);
    assign dir_wr  = bus_en && bus_we && (bus_addr == 5'h04);
    assign lat_wr  = bus_en && bus_we && (bus_addr == 5'h08 || bus_addr == 5'h0C);

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(irq_low) & ~irq_low)) |-> $past(stat_wr)); // R6

    AST_CLR_ONE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stat_wr) |-> ((($past(irq_low) & ~irq_low) & ~$past(wd_low)) == '0)); // R6

    AST_SHARED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_high) |-> $past(stat_wr)); // R8

    AST_WAKE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> ((|irq_low) || irq_high)); // R9

    AST_OE_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_oe) |-> $past(dir_wr)); // R4

    AST_LAT_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pin_out) |-> $past(lat_wr)); // R3

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi == '0); // R12

endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
    .NP(NP), .ND(ND), .HW(DW - NP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr[4:0]),
    .wd_low   (bus_wdata[ND-1:0]),
    .rd_hi    (bus_rdata[DW-1:NP]),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .irq_low  (irq_low),
    .irq_high (irq_high),
    .wake_req (wake_req)
);

// File: tb/sim_gpio_edge_ctrl.sv
module sim_gpio_edge_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [27:0] pin_in = '0;
    logic [27:0] pin_out, pin_oe;
    logic [10:0] irq_low;
    logic        irq_high, wake_req;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq_low(irq_low), .irq_high(irq_high), .wake_req(wake_req)
    );

    // ---------------- behavioural reference model ----------------
    logic [27:0] sq[$];
    logic [27:0] m_prev = '0, m_out = '0, m_dir = '0, m_ren = '0;
    logic [27:0] m_fen = '0, m_st = '0, m_wk = '0;

    initial sq = {28'h0, 28'h0};

    always @(posedge clk) begin
        logic [27:0] lv, hits, clr;
        if (!rst_n) begin
            sq = {28'h0, 28'h0};
            m_prev = '0; m_out = '0; m_dir = '0; m_ren = '0;
            m_fen = '0; m_st = '0; m_wk = '0;
        end else begin
            lv   = sq[0];
            hits = (lv & ~m_prev & m_ren) | (~lv & m_prev & m_fen);
            clr  = '0;
            if (bus_en && bus_we && bus_addr[1:0] == 2'b00) begin
                case (bus_addr[4:2])
                    3'd1: m_dir = bus_wdata[27:0];
                    3'd2: m_out = m_out | bus_wdata[27:0];
                    3'd3: m_out = m_out & ~bus_wdata[27:0];
                    3'd4: m_ren = bus_wdata[27:0];
                    3'd5: m_fen = bus_wdata[27:0];
                    3'd6: clr   = bus_wdata[27:0];
                    3'd7: m_wk  = bus_wdata[27:0];
                    default: ;
                endcase
            end
            m_st   = (m_st & ~clr) | hits;
            m_prev = lv;
            void'(sq.pop_front());
            sq.push_back(pin_in);
        end
    end

    function automatic logic [31:0] m_read();
        logic [27:0] v = '0;
        if (bus_en && !bus_we && bus_addr[1:0] == 2'b00) begin
            case (bus_addr[4:2])
                3'd0: v = sq[0];
                3'd1: v = m_dir;
                3'd2, 3'd3: v = m_out;
                3'd4: v = m_ren;
                3'd5: v = m_fen;
                3'd6: v = m_st;
                default: v = m_wk;
            endcase
        end
        return {4'h0, v};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every port against the model, then release the bus
    task automatic step();
        @(negedge clk);
        check("R3 pin_out", {4'h0, pin_out}, {4'h0, m_out});
        check("R4 pin_oe", {4'h0, pin_oe}, {4'h0, m_dir});
        check("R7 irq_low", {21'h0, irq_low}, {21'h0, m_st[10:0]});
        check("R8 irq_high", {31'h0, irq_high}, {31'h0, |m_st[27:11]});
        check("R9 wake_req", {31'h0, wake_req}, {31'h0, |(m_st & m_wk)});
        check("R2 R12 bus_rdata", bus_rdata, m_read());
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        step();
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        step();
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        step();
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R10 watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        wait_cyc(3);
        rst_n = 1'b1;
        // R10: everything zero after reset
        for (int a = 0; a < 8; a++) begin
            rd(5'(a * 4), v);
            check("R10 reset register", v, 32'h0);
        end
        step();
        check("R10 reset irq", {20'h0, irq_low, irq_high}, 32'h0);

        // R4 and R3: direction and write-one set/clear
        wr(5'h04, 32'h00F0F0F0);
        check("R4 direction", {4'h0, pin_oe}, 32'h00F0F0F0);
        wr(5'h08, 32'h00FF00FF);
        wr(5'h0C, 32'h000000F0);
        check("R3 latch after set/clear", {4'h0, pin_out}, 32'h00FF000F);
        wr(5'h08, 32'h0);
        wr(5'h0C, 32'h0);
        rd(5'h0C, v);
        check("R3 zero masks keep latch", v, 32'h00FF000F);

        // R2: level readback, both directions
        pin_in = 28'hA5A5A5A;
        wait_cyc(3);
        rd(5'h00, v);
        check("R2 level", v, 32'h0A5A5A5A);

        // R1: two-stage delay
        step();
        pin_in = 28'h5A5A5A5;
        rd(5'h00, v);
        check("R1 level after one edge", v, 32'h0A5A5A5A);
        rd(5'h00, v);
        check("R1 level after two edges", v, 32'h05A5A5A5);

        // R5: edge enables (pin0 rise, pin1 fall, pin2 both, pin11 and pin20 rise)
        step();
        pin_in = '0;
        wait_cyc(4);
        wr(5'h10, 32'h00100805);
        wr(5'h14, 32'h00000006);
        wr(5'h18, 32'h0FFFFFFF);
        step();
        pin_in = 28'h0100007;
        wait_cyc(4);
        rd(5'h18, v);
        check("R5 rising edges", v, 32'h00100005);
        step();
        check("R7 dedicated lines", {21'h0, irq_low}, 32'h005);
        check("R8 shared line", {31'h0, irq_high}, 32'h1);
        pin_in = '0;
        wait_cyc(4);
        rd(5'h18, v);
        check("R5 falling and both", v, 32'h00100007);

        // R6: write-one clears, zero ignored
        wr(5'h18, 32'h00000004);
        wr(5'h18, 32'h0);
        rd(5'h18, v);
        check("R6 sticky clear", v, 32'h00100003);

        // R9: wake mask
        wr(5'h1C, 32'h00000001);
        step();
        check("R9 wake high", {31'h0, wake_req}, 32'h1);
        wr(5'h18, 32'h00000001);
        step();
        check("R9 wake low", {31'h0, wake_req}, 32'h0);

        // R8: boundary at pin 11 lands on shared line only
        wr(5'h18, 32'h00100000);
        step();
        check("R8 shared cleared", {31'h0, irq_high}, 32'h0);
        pin_in = 28'h0000800;
        wait_cyc(4);
        check("R8 pin 11 shared", {31'h0, irq_high}, 32'h1);
        check("R7 pin 11 not dedicated", {21'h0, irq_low}, 32'h002);

        // R11: edge and clear in the same cycle
        pin_in = 28'h0000804;
        step();
        step();
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 5'h18; bus_wdata = 32'h4;
        step();
        rd(5'h18, v);
        check("R11 edge beats clear", v & 32'h4, 32'h4);

        // R12: level write ignored, misaligned ignored, upper bits zero
        wr(5'h00, 32'hFFFFFFFF);
        wr(5'h19, 32'hFFFFFFFF);
        wr(5'h05, 32'hFFFFFFFF);
        check("R12 misaligned write", {4'h0, pin_oe}, 32'h00F0F0F0);
        rd(5'h19, v);
        check("R12 misaligned read", v, 32'h0);
        rd(5'h18, v);
        check("R12 upper bits", v & 32'hF0000000, 32'h0);
        wait_cyc(2);

        summary();
        $finish;
    end

endmodule